// File: doc/BRIEF.md
# Load-Use Interlock Controller

This block is the hazard and stall unit of an in-order pipeline with the stages Fetch, Decode, Execute, Memory and Write. Every cycle it checks the source registers of the instruction in Decode against the destination registers of loads now in Execute and in Memory. From the load kind and the distance between load and consumer it works out how many stall cycles are still needed. It asserts a stall, which holds the program counter and the Fetch/Decode registers, and it asserts a bubble, which puts an invalid no-op into Execute.

The block works from the stage contents that the pipeline presents each cycle. While the consumer is held, the load moves on and its penalty drops, so the stall length counts itself down. A consumer that has already waited is never stalled again. A load whose destination is the program counter needs no compare. Instead a counter holds Execute until that load has spent `PC_EXE_CYC` cycles there. A flush clears all stall outputs and the counter.

Top module: `load_use_interlock`

## Requirements
- R1: The load-kind code is 2'b00 aligned word, 2'b01 sub-word or unaligned, 2'b10 program-counter load, and 2'b11 is handled as 2'b01. An aligned word load in Execute that the Decode instruction reads gives `stall_len_o` = 1.
- R2: An aligned word load in Memory that the Decode instruction reads gives `stall_len_o` = 0.
- R3: A sub-word load (code 01 or 11) that the Decode instruction reads gives `stall_len_o` = 2 when the load is in Execute and 1 when it is in Memory.
- R4: A stage counts as a conflict only when all of these hold:
  - the Decode instruction is valid;
  - the stage is valid and carries the load flag;
  - a source with its enable bit set has the same 4-bit number as the destination.
- R5: When both stages conflict, `stall_len_o` is the larger of the two penalties, not their sum.
- R6: When `exe_hold_o` is low, `stall_o` and `bubble_o` are both high exactly when `stall_len_o` is non-zero.
- R7: A program-counter load (code 10) in Execute does not stall through the register compare.
  - `exe_hold_o` is high for its first `PC_EXE_CYC`-1 cycles in Execute and low in the cycle after that.
  - While `exe_hold_o` is high, `stall_o` is high and `bubble_o` is low.
- R8: After a sub-word load and its consumer have seen two stall cycles and the consumer has moved into Execute, a later Decode instruction that reads the same register is not stalled.
- R9: While `flush_i` is high, every stall output is zero. The Execute hold counter restarts from zero after a flush and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Pipeline flush |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_kind_i | input | 2 | Execute load kind |
| ex_rd_i | input | REG_W | Execute destination register |
| mem_valid_i | input | 1 | Memory stage holds a valid instruction |
| mem_load_i | input | 1 | Memory instruction is a load |
| mem_kind_i | input | 2 | Memory load kind |
| mem_rd_i | input | REG_W | Memory destination register |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| dec_src_i | input | N_SRC*REG_W | Decode source registers, source s at bits s*REG_W upward |
| dec_src_en_i | input | N_SRC | Use-enable per source |
| stall_o | output | 1 | Hold the program counter and the Fetch/Decode registers |
| bubble_o | output | 1 | Load an invalid no-op into Execute |
| exe_hold_o | output | 1 | Hold the Execute register; a bubble enters Memory |
| stall_len_o | output | 2 | Stall cycles still required by the Decode instruction |

## Verification
The assertions check several relations on every cycle:
- a bubble never appears without a stall, and never together with an Execute hold;
- a flush silences every output;
- the hold counter never passes its limit, and a hold is only raised while a program-counter load sits in Execute.

Only the bench scenarios can show the actual stall lengths. The bench sweeps every load kind, stage state and source pattern. It also walks a sub-word load through its two stall cycles and then checks that no second stall follows. It times the five-cycle Execute occupancy and shows that a flush cuts that occupancy short.

// File: rtl/lui_pkg.sv
package lui_pkg;
  typedef enum logic [1:0] {
    LD_WORD = 2'b00,
    LD_SUB  = 2'b01,
    LD_PC   = 2'b10,
    LD_RSV  = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/lui_stage_match.sv
module lui_stage_match
  import lui_pkg::*;
#(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned REG_W = 4,
  parameter bit          NEAR  = 1'b1  // 1: stage right behind Decode
) (
  input  logic                   dec_valid_i,
  input  logic [N_SRC*REG_W-1:0] src_i,
  input  logic [N_SRC-1:0]       src_en_i,
  input  logic                   valid_i,
  input  logic                   load_i,
  input  logic [1:0]             kind_i,
  input  logic [REG_W-1:0]       rd_i,
  output logic [1:0]             pen_o
);
  logic [N_SRC-1:0] hit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign hit[s] = src_en_i[s] && (src_i[s*REG_W +: REG_W] == rd_i);
  end

  logic conflict, slow;
  assign conflict = dec_valid_i && valid_i && load_i && (|hit) &&
                    (ld_kind_e'(kind_i) != LD_PC);
  assign slow     = (ld_kind_e'(kind_i) != LD_WORD);

  always_comb begin
    pen_o = 2'd0;
    if (conflict) begin
      if (NEAR) pen_o = slow ? 2'd2 : 2'd1;
      else      pen_o = slow ? 2'd1 : 2'd0;
    end
  end
endmodule

// File: rtl/lui_pc_hold.sv
module lui_pc_hold #(
  parameter int unsigned PC_EXE_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic pc_in_e_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = (PC_EXE_CYC > 2) ? $clog2(PC_EXE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PC_EXE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign hold_o = pc_in_e_i && !flush_i && (cnt_q < LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else if (hold_o)  cnt_q <= cnt_q + 1'b1;
    else              cnt_q <= '0;
  end

  assert_cnt_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_hold_needs_pc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> pc_in_e_i);
  assert_flush_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lui_pkg::*;
#(
  parameter int unsigned N_SRC      = 3,
  parameter int unsigned REG_W      = 4,
  parameter int unsigned PC_EXE_CYC = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   ex_valid_i,
  input  logic                   ex_load_i,
  input  logic [1:0]             ex_kind_i,
  input  logic [REG_W-1:0]       ex_rd_i,
  input  logic                   mem_valid_i,
  input  logic                   mem_load_i,
  input  logic [1:0]             mem_kind_i,
  input  logic [REG_W-1:0]       mem_rd_i,
  input  logic                   dec_valid_i,
  input  logic [N_SRC*REG_W-1:0] dec_src_i,
  input  logic [N_SRC-1:0]       dec_src_en_i,
  output logic                   stall_o,
  output logic                   bubble_o,
  output logic                   exe_hold_o,
  output logic [1:0]             stall_len_o
);
  logic [1:0] pen_ex, pen_mem, pen_max;
  logic       pc_in_e;

  lui_stage_match #(.N_SRC(N_SRC), .REG_W(REG_W), .NEAR(1'b1)) i_match_ex (
    .dec_valid_i(dec_valid_i), .src_i(dec_src_i), .src_en_i(dec_src_en_i),
    .valid_i(ex_valid_i), .load_i(ex_load_i), .kind_i(ex_kind_i),
    .rd_i(ex_rd_i), .pen_o(pen_ex)
  );

  lui_stage_match #(.N_SRC(N_SRC), .REG_W(REG_W), .NEAR(1'b0)) i_match_mem (
    .dec_valid_i(dec_valid_i), .src_i(dec_src_i), .src_en_i(dec_src_en_i),
    .valid_i(mem_valid_i), .load_i(mem_load_i), .kind_i(mem_kind_i),
    .rd_i(mem_rd_i), .pen_o(pen_mem)
  );

  assign pc_in_e = ex_valid_i && ex_load_i && (ld_kind_e'(ex_kind_i) == LD_PC);

  lui_pc_hold #(.PC_EXE_CYC(PC_EXE_CYC)) i_pc_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .pc_in_e_i(pc_in_e), .hold_o(exe_hold_o)
  );

  // worst case over in-flight loads, never the sum
  assign pen_max     = (pen_ex > pen_mem) ? pen_ex : pen_mem;
  assign stall_len_o = flush_i ? 2'd0 : pen_max;
  assign stall_o     = !flush_i && ((pen_max != 2'd0) || exe_hold_o);
  assign bubble_o    = !flush_i && !exe_hold_o && (pen_max != 2'd0);

  assert_bubble_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> stall_o);
  assert_hold_no_bubble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_hold_o |-> (stall_o && !bubble_o));
  assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!stall_o && !bubble_o && !exe_hold_o && stall_len_o == 2'd0));
  assert_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_len_o <= 2'd2);
  assert_mem_word_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_valid_i && mem_kind_i == 2'b00) |-> (stall_len_o == 2'd0));
endmodule

// File: tb/test_load_use_interlock.sv
`timescale 1ns/1ps
module test_load_use_interlock;
  localparam int N_SRC = 3;
  localparam int REG_W = 4;
  localparam int PC_EXE_CYC = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush = 1'b0;
  logic ex_v = 1'b0, ex_l = 1'b0, mem_v = 1'b0, mem_l = 1'b0, dec_v = 1'b0;
  logic [1:0] ex_k = 2'b00, mem_k = 2'b00;
  logic [REG_W-1:0] ex_rd = 4'd5, mem_rd = 4'd9;
  logic [N_SRC*REG_W-1:0] src = '0;
  logic [N_SRC-1:0] src_en = '0;
  logic stall, bubble, hold;
  logic [1:0] len;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  load_use_interlock #(.N_SRC(N_SRC), .REG_W(REG_W), .PC_EXE_CYC(PC_EXE_CYC))
  i_load_use_interlock (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .ex_valid_i(ex_v), .ex_load_i(ex_l), .ex_kind_i(ex_k), .ex_rd_i(ex_rd),
    .mem_valid_i(mem_v), .mem_load_i(mem_l), .mem_kind_i(mem_k), .mem_rd_i(mem_rd),
    .dec_valid_i(dec_v), .dec_src_i(src), .dec_src_en_i(src_en),
    .stall_o(stall), .bubble_o(bubble), .exe_hold_o(hold), .stall_len_o(len)
  );

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_len, input int e_hold);
    int e_stall, e_bub;
    e_stall = (e_len != 0 || e_hold != 0) ? 1 : 0;
    e_bub   = (e_len != 0 && e_hold == 0) ? 1 : 0;
    chk({tag, " len"},    int'(len),    e_len);
    chk({tag, " stall"},  int'(stall),  e_stall);
    chk({tag, " bubble"}, int'(bubble), e_bub);
    chk({tag, " hold"},   int'(hold),   e_hold);
  endtask

  task automatic idle();
    ex_v = 0; ex_l = 0; ex_k = 0; mem_v = 0; mem_l = 0; mem_k = 0;
    dec_v = 0; src = '0; src_en = '0; flush = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all("reset R9", 0, 0);
    rst_ni = 1'b1;

    // sweep R1 R2 R3 R4 R5 R6: stage state x kind x source pattern
    for (int dv = 0; dv < 2; dv++)
    for (int es = 0; es < 3; es++)
    for (int ek = 0; ek < 3; ek++)
    for (int ms = 0; ms < 3; ms++)
    for (int mk = 0; mk < 3; mk++)
    for (int pat = 0; pat < 27; pat++)
    for (int en = 0; en < 8; en++) begin
      int c[3];
      int he, hm, pe, pm, ex;
      logic [1:0] ekc, mkc;
      @(negedge clk);
      ekc = (ek == 2) ? 2'b11 : 2'(ek);
      mkc = (mk == 2) ? 2'b11 : 2'(mk);
      c[0] = pat % 3; c[1] = (pat / 3) % 3; c[2] = pat / 9;
      dec_v = dv[0];
      ex_v = (es != 0); ex_l = (es == 2); ex_k = ekc;
      mem_v = (ms != 0); mem_l = (ms == 2); mem_k = mkc;
      he = 0; hm = 0;
      for (int s = 0; s < 3; s++) begin
        src[s*REG_W +: REG_W] = (c[s] == 0) ? 4'd5 : (c[s] == 1) ? 4'd9 : 4'd12;
        if (en[s] && c[s] == 0) he = 1;
        if (en[s] && c[s] == 1) hm = 1;
      end
      src_en = 3'(en);
      pe = (dv == 1 && es == 2 && he == 1) ? ((ek == 0) ? 1 : 2) : 0;
      pm = (dv == 1 && ms == 2 && hm == 1) ? ((mk == 0) ? 0 : 1) : 0;
      ex = (pe > pm) ? pe : pm;
      #5;
      chk_all("sweep R1 R2 R3 R4 R5 R6", ex, 0);
    end

    // R5: same register in both stages
    @(negedge clk); idle();
    dec_v = 1; ex_rd = 4'd7; mem_rd = 4'd7;
    src[3:0] = 4'd7; src_en = 3'b001;
    ex_v = 1; ex_l = 1; ex_k = 2'b00; mem_v = 1; mem_l = 1; mem_k = 2'b01;
    #5; chk_all("max word+sub R5", 1, 0);
    @(negedge clk); ex_k = 2'b01;
    #5; chk_all("max sub+sub R5", 2, 0);

    // R8: sub-word load walks down, consumer waits twice then never again
    @(negedge clk); idle(); ex_rd = 4'd5; mem_rd = 4'd5;
    dec_v = 1; src[7:4] = 4'd5; src_en = 3'b010;
    ex_v = 1; ex_l = 1; ex_k = 2'b01;
    #5; chk_all("seq stall1 R8", 2, 0);
    @(negedge clk); ex_v = 0; ex_l = 0; mem_v = 1; mem_l = 1; mem_k = 2'b01;
    #5; chk_all("seq stall2 R8", 1, 0);
    @(negedge clk); ex_v = 1; ex_l = 0; mem_v = 0; mem_l = 0;
    src[11:8] = 4'd5; src_en = 3'b110;
    #5; chk_all("seq no restall R8", 0, 0);

    // R7: program-counter load occupies Execute PC_EXE_CYC cycles
    @(negedge clk); idle(); dec_v = 1; src[3:0] = 4'd15; src_en = 3'b001;
    ex_rd = 4'd15; ex_v = 1; ex_l = 1; ex_k = 2'b10;
    for (int i = 0; i < PC_EXE_CYC - 1; i++) begin
      #5; chk_all("pc hold R7", 0, 1);
      @(negedge clk);
    end
    #5; chk_all("pc release R7", 0, 0);
    @(negedge clk); ex_v = 0; ex_l = 0;
    #5; chk_all("pc gone R7", 0, 0);

    // R9: flush during hold, then a fresh PC load gets the full hold
    @(negedge clk); ex_v = 1; ex_l = 1; ex_k = 2'b10;
    #5; chk_all("pc hold pre-flush R7", 0, 1);
    @(negedge clk);
    #5; chk_all("pc hold 2 R7", 0, 1);
    @(negedge clk); flush = 1; mem_v = 1; mem_l = 1; mem_k = 2'b01;
    mem_rd = 4'd15;
    #5; chk_all("flush quiet R9", 0, 0);
    @(negedge clk); flush = 0; mem_v = 0; mem_l = 0;
    for (int i = 0; i < PC_EXE_CYC - 1; i++) begin
      #5; chk_all("hold after flush R9", 0, 1);
      @(negedge clk);
    end
    #5; chk_all("release after flush R9", 0, 0);

    // R9: reset mid-hold restarts the count
    @(negedge clk); ex_v = 0;
    @(negedge clk); ex_v = 1;
    #5; chk_all("hold pre-reset R9", 0, 1);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    for (int i = 0; i < PC_EXE_CYC - 1; i++) begin
      #5; chk_all("hold after reset R9", 0, 1);
      @(negedge clk);
    end
    #5; chk_all("release after reset R9", 0, 0);

    @(negedge clk); idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule